// File: doc/BRIEF.md
# Slave PCM Serial Port Transmitter (Two-Channel or Eight-Slot)

This block serialises one stereo pair of 20-bit PCM words per audio frame onto a single shared serial data line. It is a timing slave: the bit clock and the frame clock arrive from outside. Both are oversampled by the block's own system clock, and the only pin the block drives is the data line. A static format input selects a two-channel format or an eight-slot time-multiplexed format. In the eight-slot format the stereo pair occupies the first two slots. Outside its active bits the line is released to high impedance, so other transmitters can share it.

The number of bit clocks per frame is not configured. The block counts bit-clock rising edges between frame starts and derives the channel window and slot width from that count. Samples come from an upstream filter stage through a valid/ready interface that feeds a one-deep holding register. `in_ready_o` is high only while that register is empty. A word offered while `in_ready_o` is low is not taken, and the source must hold it until it is accepted. At each frame start the held pair moves into the active register and `smp_load_o` pulses for one cycle. If nothing new was accepted, the previous pair is sent again.

Top module: `pcm_slot_serializer`

## Requirements
- R1: `sdata_oe_o` and `sdata_bit_o` change only in the system clock cycle after a detected falling edge of `bclk_i`, and they hold their value across the following rising edge.
- R2: Each channel drives at most 20 bits, MSB first, on consecutive bit positions. Every other bit position of its window or slot has `sdata_oe_o` = 0, and then `sdata_o` is high impedance.
- R3: With `fmt_i2s_i` = 1, a frame starts at a bit-clock rising edge that samples `lrclk_i` low after sampling it high on the previous rising edge. Bit positions n count rising edges from that edge, with n = 0 at the frame start. The left MSB is at n = 1, and the right MSB is at n = L/2 + 1, where L is the number of bit clocks per frame.
- R4: With `fmt_i2s_i` = 0, a frame starts at a rising edge that samples `lrclk_i` high after sampling it low. The slot width is S = L/8. The left MSB is at n = 0 and the right MSB is at n = S. Slots 3 to 8 are never driven.
- R5: L is measured at every frame start and may be 64, 128, 192, 256, 384 or 512. The number of bits driven per channel is min(20, L/2 - 1) in the two-channel format and min(20, S) in the eight-slot format.
- R6: `in_ready_o` is 1 exactly when the holding register is empty. A pair is taken on a cycle with `in_valid_i` and `in_ready_o` both high. A pair offered while `in_ready_o` is 0 is ignored.
- R7: The held pair moves to the active register at the falling edge that drives the left MSB. `smp_load_o` is a one-cycle pulse in the cycle after that edge is detected, and the holding register is empty afterwards.
- R8: If no pair was taken since the last load, the next frame repeats the previous pair.
- R9: After reset `sdata_oe_o` stays 0. The first detected frame start arms the measurement and the second one locks it. Driving begins at the first left-MSB position after lock: frame index 2 in the two-channel format and frame index 3 in the eight-slot format, counting the first frame the bench sends as index 0.
- R10: Once locked, `smp_load_o` pulses exactly once per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_i2s_i | input | 1 | Static format: 1 = two-channel, 0 = eight-slot |
| bclk_i | input | 1 | External bit clock |
| lrclk_i | input | 1 | External frame clock |
| in_valid_i | input | 1 | Upstream pair valid |
| in_ready_o | output | 1 | Holding register empty |
| in_left_i | input | 20 | Left PCM word |
| in_right_i | input | 20 | Right PCM word |
| smp_load_o | output | 1 | One-cycle pulse at each pair load |
| sdata_o | output | 1 | Serial data line, high impedance when not driving |
| sdata_oe_o | output | 1 | Drive enable of the data line |
| sdata_bit_o | output | 1 | Bit value presented on the data line |

## Verification
The hardest situation to reach is the frame-start boundary in the eight-slot format. There the left MSB must go out on the falling edge before the frame clock pulse is even sampled, so the block depends entirely on the measured frame length. The bench reaches it by sweeping every supported bit-clock ratio in both formats from reset through the arm and lock frames and into several driven frames. At every bit position it compares the enable and the bit against the position arithmetic, including the truncated slots at 64 and 128 clocks. The same sweep also covers a skipped push, which must give a repeated frame, and a push offered while the holding register is full, which must be refused.

// File: rtl/pcm_ser_pkg.sv
package pcm_ser_pkg;
  typedef enum logic {
    FMT_TDM8 = 1'b0,
    FMT_I2S  = 1'b1
  } ser_fmt_e;
endpackage

// File: rtl/pcm_ser_edge_sync.sv
module pcm_ser_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_i,
  input  logic lrclk_i,
  output logic rise_o,
  output logic fall_o,
  output logic lr_o
);
  localparam int unsigned TOP = STAGES - 1;

  logic [STAGES-1:0] b_sh;
  logic [STAGES-1:0] l_sh;
  logic              b_last;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          b_sh <= '1;
          l_sh <= '0;
        end else begin
          b_sh <= bclk_i;
          l_sh <= lrclk_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          b_sh <= '1;
          l_sh <= '0;
        end else begin
          b_sh <= {b_sh[STAGES-2:0], bclk_i};
          l_sh <= {l_sh[STAGES-2:0], lrclk_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) b_last <= 1'b1;
    else        b_last <= b_sh[TOP];
  end

  assign rise_o = b_sh[TOP] & ~b_last;
  assign fall_o = ~b_sh[TOP] & b_last;
  assign lr_o   = l_sh[TOP];
endmodule

// File: rtl/pcm_ser_frame_track.sv
module pcm_ser_frame_track
  import pcm_ser_pkg::*;
#(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ser_fmt_e         fmt,
  input  logic             rise_i,
  input  logic             lr_i,
  output logic [CNT_W-1:0] pos_o,
  output logic [CNT_W-1:0] len_o,
  output logic             locked_o
);
  logic             have_prev;
  logic             lr_prev;
  logic             armed;
  logic             locked;
  logic [CNT_W-1:0] pos_q;
  logic [CNT_W-1:0] len_q;
  logic             edge_ok;
  logic             frame_hit;

  always_comb begin
    if (fmt == FMT_I2S) edge_ok = lr_prev & ~lr_i;
    else                edge_ok = ~lr_prev & lr_i;
    frame_hit = rise_i & have_prev & edge_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      lr_prev   <= 1'b0;
      armed     <= 1'b0;
      locked    <= 1'b0;
      pos_q     <= '0;
      len_q     <= '0;
    end else if (rise_i) begin
      have_prev <= 1'b1;
      lr_prev   <= lr_i;
      if (frame_hit) begin
        pos_q <= '0;
        armed <= 1'b1;
        if (armed) begin
          len_q  <= pos_q + CNT_W'(1);
          locked <= 1'b1;
        end
      end else if (locked && (pos_q == len_q - CNT_W'(1))) begin
        pos_q <= '0;
      end else if (pos_q != '1) begin
        pos_q <= pos_q + CNT_W'(1);
      end
    end
  end

  assign pos_o    = pos_q;
  assign len_o    = len_q;
  assign locked_o = locked;
endmodule

// File: rtl/pcm_ser_hold.sv
module pcm_ser_hold #(
  parameter int unsigned W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] in_left_i,
  input  logic [W-1:0] in_right_i,
  input  logic         take_i,
  output logic [W-1:0] fresh_l_o,
  output logic [W-1:0] fresh_r_o,
  output logic [W-1:0] act_l_o,
  output logic [W-1:0] act_r_o
);
  logic         full;
  logic [W-1:0] hold_l;
  logic [W-1:0] hold_r;
  logic [W-1:0] act_l;
  logic [W-1:0] act_r;
  logic         accept;

  assign in_ready_o = ~full;
  assign accept     = in_valid_i & ~full;
  assign fresh_l_o  = full ? hold_l : act_l;
  assign fresh_r_o  = full ? hold_r : act_r;
  assign act_l_o    = act_l;
  assign act_r_o    = act_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full   <= 1'b0;
      hold_l <= '0;
      hold_r <= '0;
      act_l  <= '0;
      act_r  <= '0;
    end else begin
      if (take_i) begin
        act_l <= fresh_l_o;
        act_r <= fresh_r_o;
        full  <= 1'b0;
      end
      if (accept) begin
        hold_l <= in_left_i;
        hold_r <= in_right_i;
        full   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pcm_ser_bit_drive.sv
module pcm_ser_bit_drive
  import pcm_ser_pkg::*;
#(
  parameter int unsigned W     = 20,
  parameter int unsigned CNT_W = 10,
  parameter int unsigned SLOTS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ser_fmt_e         fmt,
  input  logic             fall_i,
  input  logic             locked_i,
  input  logic [CNT_W-1:0] pos_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic [W-1:0]     fresh_l_i,
  input  logic [W-1:0]     fresh_r_i,
  input  logic [W-1:0]     act_l_i,
  input  logic [W-1:0]     act_r_i,
  output logic             take_o,
  output logic             load_o,
  output logic             oe_o,
  output logic             bit_o
);
  localparam int unsigned SLOT_SH = $clog2(SLOTS);
  localparam int unsigned IDX_W   = (W > 1) ? $clog2(W) : 1;

  logic [CNT_W-1:0] nxt;
  logic [CNT_W-1:0] half;
  logic [CNT_W-1:0] slot;
  logic [CNT_W-1:0] span;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] l_start;
  logic [CNT_W-1:0] r_start;
  logic [CNT_W-1:0] off;
  logic             in_l;
  logic             in_r;
  logic [W-1:0]     src_l;
  logic [W-1:0]     src_r;
  logic [IDX_W-1:0] idx;
  logic             started;
  logic             drv_next;
  logic             bit_next;

  always_comb begin
    nxt   = (pos_i == len_i - CNT_W'(1)) ? '0 : pos_i + CNT_W'(1);
    half  = len_i >> 1;
    slot  = len_i >> SLOT_SH;
    if (fmt == FMT_I2S) begin
      span    = half - CNT_W'(1);
      l_start = CNT_W'(1);
      r_start = half + CNT_W'(1);
    end else begin
      span    = slot;
      l_start = '0;
      r_start = slot;
    end
    cnt    = (span > CNT_W'(W)) ? CNT_W'(W) : span;
    take_o = fall_i & locked_i & (nxt == l_start);
    in_l   = (nxt >= l_start) && (nxt < l_start + cnt);
    in_r   = (nxt >= r_start) && (nxt < r_start + cnt);
    off    = in_l ? (nxt - l_start) : (nxt - r_start);
    idx    = IDX_W'(W - 1) - off[IDX_W-1:0];
    src_l  = take_o ? fresh_l_i : act_l_i;
    src_r  = take_o ? fresh_r_i : act_r_i;
    drv_next = (started | take_o) & (in_l | in_r);
    if (!drv_next) bit_next = 1'b0;
    else if (in_l) bit_next = src_l[idx];
    else           bit_next = src_r[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started <= 1'b0;
      oe_o    <= 1'b0;
      bit_o   <= 1'b0;
      load_o  <= 1'b0;
    end else begin
      load_o <= take_o;
      if (take_o) started <= 1'b1;
      if (fall_i && locked_i) begin
        oe_o  <= drv_next;
        bit_o <= bit_next;
      end
    end
  end
endmodule

// File: rtl/pcm_slot_serializer.sv
module pcm_slot_serializer
  import pcm_ser_pkg::*;
#(
  parameter int unsigned SAMPLE_W    = 20,
  parameter int unsigned SLOTS       = 8,
  parameter int unsigned MAX_BPF     = 512,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fmt_i2s_i,
  input  logic                bclk_i,
  input  logic                lrclk_i,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic [SAMPLE_W-1:0] in_left_i,
  input  logic [SAMPLE_W-1:0] in_right_i,
  output logic                smp_load_o,
  output logic                sdata_o,
  output logic                sdata_oe_o,
  output logic                sdata_bit_o
);
  localparam int unsigned CNT_W = $clog2(MAX_BPF + 1);

  ser_fmt_e            fmt;
  logic                bclk_rise;
  logic                bclk_fall;
  logic                lr_s;
  logic [CNT_W-1:0]    trk_pos;
  logic [CNT_W-1:0]    trk_len;
  logic                trk_locked;
  logic                take;
  logic [SAMPLE_W-1:0] fresh_l;
  logic [SAMPLE_W-1:0] fresh_r;
  logic [SAMPLE_W-1:0] act_l;
  logic [SAMPLE_W-1:0] act_r;

  assign fmt = fmt_i2s_i ? FMT_I2S : FMT_TDM8;

  pcm_ser_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i), .lrclk_i(lrclk_i),
    .rise_o(bclk_rise), .fall_o(bclk_fall), .lr_o(lr_s)
  );

  pcm_ser_frame_track #(.CNT_W(CNT_W)) u_track (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .rise_i(bclk_rise), .lr_i(lr_s),
    .pos_o(trk_pos), .len_o(trk_len), .locked_o(trk_locked)
  );

  pcm_ser_hold #(.W(SAMPLE_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .in_left_i(in_left_i), .in_right_i(in_right_i), .take_i(take),
    .fresh_l_o(fresh_l), .fresh_r_o(fresh_r), .act_l_o(act_l), .act_r_o(act_r)
  );

  pcm_ser_bit_drive #(.W(SAMPLE_W), .CNT_W(CNT_W), .SLOTS(SLOTS)) u_drive (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .fall_i(bclk_fall),
    .locked_i(trk_locked), .pos_i(trk_pos), .len_i(trk_len),
    .fresh_l_i(fresh_l), .fresh_r_i(fresh_r), .act_l_i(act_l), .act_r_i(act_r),
    .take_o(take), .load_o(smp_load_o), .oe_o(sdata_oe_o), .bit_o(sdata_bit_o)
  );

  assign sdata_o = sdata_oe_o ? sdata_bit_o : 1'bz;
endmodule

// File: rtl/pcm_slot_serializer_chk.sv
module pcm_slot_serializer_chk (
  input logic clk,
  input logic rst_n,
  input logic bclk_fall,
  input logic trk_locked,
  input logic in_valid_i,
  input logic in_ready_o,
  input logic smp_load_o,
  input logic sdata_oe_o,
  input logic sdata_bit_o
);
  AST_OUT_ONLY_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bclk_fall) |-> ($stable(sdata_oe_o) && $stable(sdata_bit_o))); // R1

  AST_QUIET_UNTIL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !trk_locked |-> !sdata_oe_o); // R9

  AST_LOAD_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_load_o |=> !smp_load_o); // R10

  AST_LOAD_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    smp_load_o |-> $past(bclk_fall)); // R7

  AST_READY_DROPS_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && in_ready_o) |=> !in_ready_o); // R6
endmodule

bind pcm_slot_serializer pcm_slot_serializer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bclk_fall(bclk_fall), .trk_locked(trk_locked),
  .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .smp_load_o(smp_load_o),
  .sdata_oe_o(sdata_oe_o), .sdata_bit_o(sdata_bit_o)
);

// File: tb/pcm_slot_serializer_tb_top.sv
module pcm_slot_serializer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fmt_i2s = 1'b1;
  logic        bclk = 1'b1;
  logic        lrclk = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [19:0] in_left = '0;
  logic [19:0] in_right = '0;
  logic        smp_load;
  logic        sdata;
  logic        sdata_oe;
  logic        sdata_bit;

  int n_vec = 0;
  int n_bad = 0;
  int load_cnt = 0;
  int push_no = 0;

  always #5 clk = ~clk;

  pcm_slot_serializer dut_i (
    .clk(clk), .rst_n(rst_n), .fmt_i2s_i(fmt_i2s), .bclk_i(bclk), .lrclk_i(lrclk),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_left_i(in_left),
    .in_right_i(in_right), .smp_load_o(smp_load), .sdata_o(sdata),
    .sdata_oe_o(sdata_oe), .sdata_bit_o(sdata_bit)
  );

  always @(posedge clk) if (rst_n && smp_load) load_cnt <= load_cnt + 1;

  task automatic check(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [19:0] mk_left(input int k, input int bpf, input bit i2s);
    return 20'((k * 32'h2F1D3 + bpf * 7 + int'(i2s)) & 32'hFFFFF);
  endfunction

  // Expected enable and bit at position n (R2, R3, R4, R5)
  task automatic expect_bit(input bit i2s, input int bpf, input int n,
                            input logic [19:0] l, input logic [19:0] r,
                            output bit oe, output bit b);
    int half = bpf / 2;
    int slot = bpf / 8;
    int span = i2s ? half - 1 : slot;
    int cnt  = (span < 20) ? span : 20;
    int ls   = i2s ? 1 : 0;
    int rs   = i2s ? half + 1 : slot;
    oe = 1'b0;
    b  = 1'b0;
    if (n >= ls && n < ls + cnt) begin
      oe = 1'b1; b = l[19 - (n - ls)];
    end else if (n >= rs && n < rs + cnt) begin
      oe = 1'b1; b = r[19 - (n - rs)];
    end
  endtask

  task automatic run_cfg(input bit i2s, input int bpf);
    int drive_from = i2s ? 2 : 3;
    int nframes = drive_from + 3;
    int skip = drive_from;
    logic [19:0] cur_l = '0, cur_r = '0, new_l = '0, new_r = '0;
    bit pend = 1'b0;
    rst_n = 1'b0; fmt_i2s = i2s; bclk = 1'b1; lrclk = 1'b0; in_valid = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    load_cnt = 0;
    check("R6 ready after reset", int'(in_ready), 1);
    check("R9 oe after reset", int'(sdata_oe), 0);
    check("R7 no load after reset", int'(smp_load), 0);
    for (int f = 0; f < nframes; f++) begin
      if (pend) begin cur_l = new_l; cur_r = new_r; pend = 1'b0; end
      for (int n = 0; n < bpf; n++) begin
        bit eo, eb;
        string tag;
        @(negedge clk);
        bclk = 1'b0;
        lrclk = i2s ? (n >= bpf / 2) : (n == 0);
        @(negedge clk);
        if (n == bpf / 4 && f >= drive_from - 1 && f <= nframes - 2 && f != skip) begin
          check("R6 ready before push", int'(in_ready), 1);
          push_no++;
          new_l = mk_left(push_no, bpf, i2s);
          new_r = new_l ^ 20'hA5C3E;
          in_left = new_l; in_right = new_r; in_valid = 1'b1;
          pend = 1'b1;
        end else if (n == bpf / 4 + 1 && f == drive_from - 1) begin
          check("R6 ready low while full", int'(in_ready), 0);
          in_left = 20'h0F0F0; in_right = 20'h33333; in_valid = 1'b1;
        end
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        if (f < drive_from) begin
          eo = 1'b0; eb = 1'b0; tag = "R9";
        end else begin
          expect_bit(i2s, bpf, n, cur_l, cur_r, eo, eb);
          if (f == skip + 1) tag = "R8";
          else if (!eo) tag = "R2";
          else if (bpf <= 128) tag = "R5";
          else tag = i2s ? "R3" : "R4";
        end
        check({tag, " oe"}, int'(sdata_oe), int'(eo));
        if (eo) check({tag, " bit"}, int'(sdata_bit), int'(eb));
        @(negedge clk);
        bclk = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 oe held over rise", int'(sdata_oe), int'(eo));
        if (eo) check("R1 bit held over rise", int'(sdata_bit), int'(eb));
      end
    end
    repeat (8) @(negedge clk);
    check("R10 loads per run", load_cnt, 3);
    check("R7 ready after last load", int'(in_ready), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int ratios[6] = '{64, 128, 192, 256, 384, 512};
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < 6; i++) run_cfg(m == 0, ratios[i]);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule